// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block is the sending half of a classic asynchronous serial port. Bytes are written into a small transmit queue. The queue can also be built as a single holding register. The block then sends each byte on one serial line. Each frame starts with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, then the high stop bits. The line rests high between frames.

The frame shape comes from a set of static configuration inputs:
- the number of data bits (5 to 8);
- the number of stop bits;
- the parity mode;
- a break control that forces the line low.

Bit timing comes from an internal divisor counter. It gives one tick every `divisor` clocks, and one bit lasts sixteen ticks. When automatic clear-to-send gating is on, a frame may begin only while the clear-to-send input is active. Two status outputs tell the host whether the queue is empty and whether the whole transmitter is idle.

Top module: `async_tx`

## Requirements
- R1: After reset `txOut` is 1, `holdEmpty` is 1 and `txEmpty` is 1. While no frame is being sent and `breakOn` is 0, `txOut` stays 1.
- R2: A frame is one start bit of 0, then the data bits least significant first, then the optional parity bit, then the stop bits at 1.
- R3: `wordSel` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The unused upper bits of the written byte are not sent.
- R4: Parity is controlled by `parityEn`, `parityEven` and `parityStick`:
  - `parityEn`=0: no parity bit is sent.
  - `parityEn`=1, `parityStick`=0: the parity bit makes the count of ones in data plus parity odd when `parityEven`=0, and even when `parityEven`=1.
  - `parityEn`=1, `parityStick`=1: the parity bit is a constant 1 when `parityEven`=0, and a constant 0 when `parityEven`=1.
- R5: With `stopSel`=0, the stop time is one bit period. With `stopSel`=1, it is 1.5 bit periods when `wordSel`=0 and 2 bit periods otherwise.
- R6: Each bit lasts 16 × D clocks. D is the last value written through `divWrEn`/`divValue`, where 0 counts as 1. D is 1 after reset. A divisor write restarts the tick counter.
- R7: While `breakOn` is 1, `txOut` is 0, whatever transfer is in progress.
- R8: While `autoCtsEn` is 1 and `ctsIn` is 0, no new frame starts. Queued bytes wait, and the line stays at 1.
- R9: `holdEmpty` is 1 exactly when the queue holds no byte. `txEmpty` is 1 only when the queue is empty and no frame is in progress.
  - A write makes both 0 at the next clock edge.
  - With D=1 and the gate open, the byte is taken at the following edge. At that point `holdEmpty` returns to 1 while `txEmpty` stays 0.
- R10: Queued bytes are sent in write order. A frame follows the previous stop time with no idle gap, so consecutive start edges are exactly one frame length apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write one byte into the transmit queue |
| wrData | input | 8 | Byte to queue |
| divWrEn | input | 1 | Load a new divisor |
| divValue | input | 16 | Divisor value; 0 counts as 1 |
| wordSel | input | 2 | Data bit count select (5 + value) |
| stopSel | input | 1 | Long stop time select |
| parityEn | input | 1 | Parity bit enable |
| parityEven | input | 1 | Even parity, or the stick value select |
| parityStick | input | 1 | Constant parity select |
| breakOn | input | 1 | Force the line low |
| autoCtsEn | input | 1 | Gate frame starts on `ctsIn` |
| ctsIn | input | 1 | Clear-to-send, active high |
| txOut | output | 1 | Serial data output |
| holdEmpty | output | 1 | Transmit queue empty |
| txEmpty | output | 1 | Queue empty and no frame in progress |

## Verification
A bit counter that is off by one shows up at `txOut` within the first frame. Such a fault either drops or repeats a data bit, or it moves the parity bit. This is visible at the mid-bit samples of that frame.

A wrong tick count or a wrong stop length changes the distance between the start edges of chained frames. A sticky or early busy state shows up on `txEmpty` and `holdEmpty` within a clock or two of the write. A fault in the gate instead shows up as a frame leaving while clear-to-send is held off.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;
  localparam int TICKS_PER_BIT = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic load;   // take a byte from the queue into the shifter
    logic shift;  // advance to the next data bit
  } dpStrobe_t;
endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divValue,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] effDiv;

  assign effDiv = (divReg == '0) ? ONE : divReg;
  assign tick   = (cnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= ONE;
      cnt    <= ONE;
    end else if (divWrEn) begin
      divReg <= divValue;
      cnt    <= (divValue == '0) ? ONE : divValue;
    end else if (cnt <= ONE) begin
      cnt <= effDiv;
    end else begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty
);
  generate
    if (DEPTH <= 1) begin : g_hold
      logic             full;
      logic [WIDTH-1:0] holdReg;
      assign empty   = !full;
      assign popData = holdReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          full    <= 1'b0;
          holdReg <= '0;
        end else if (push && (!full || pop)) begin
          full    <= 1'b1;
          holdReg <= pushData;
        end else if (pop) begin
          full <= 1'b0;
        end
      end
    end else begin : g_ring
      localparam int AW = $clog2(DEPTH);
      localparam logic [AW:0]   DEPTH_C = (AW+1)'(DEPTH);
      localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

      logic [WIDTH-1:0] mem [DEPTH];
      logic [AW-1:0]    wrPtr;
      logic [AW-1:0]    rdPtr;
      logic [AW:0]      count;
      logic             doPush;
      logic             doPop;

      assign empty   = (count == '0);
      assign popData = mem[rdPtr];
      assign doPop   = pop && !empty;
      assign doPush  = push && ((count != DEPTH_C) || doPop);

      always_ff @(posedge clk) begin
        if (doPush) mem[wrPtr] <= pushData;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wrPtr <= '0;
          rdPtr <= '0;
          count <= '0;
        end else begin
          if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
          if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
          if (doPush && !doPop)      count <= count + 1'b1;
          else if (doPop && !doPush) count <= count - 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       fifoEmpty,
  input  logic       ctsOk,
  input  logic [1:0] wordSel,
  input  logic       stopSel,
  input  logic       parityEn,
  output dpStrobe_t  strobe,
  output txState_t   state,
  output logic       busy
);
  localparam logic [4:0] BIT_LAST = 5'(TICKS_PER_BIT - 1);

  logic [4:0] tickCnt;
  logic [2:0] bitCnt;
  logic [2:0] bitLast;
  logic [4:0] stopLast;
  logic       startOk;
  logic       bitEnd;
  logic       stopEnd;

  assign bitLast  = {1'b0, wordSel} + 3'd4;
  assign stopLast = !stopSel ? BIT_LAST : ((wordSel == 2'd0) ? 5'd23 : 5'd31);
  assign startOk  = !fifoEmpty && ctsOk;
  assign bitEnd   = tick && (tickCnt == BIT_LAST);
  assign stopEnd  = tick && (state == ST_STOP) && (tickCnt == stopLast);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    strobe       = '0;
    strobe.load  = tick && startOk && ((state == ST_IDLE) || stopEnd);
    strobe.shift = bitEnd && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tick) begin
      tickCnt <= tickCnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (startOk) state <= ST_START;
        end
        ST_START: if (bitEnd) begin
          tickCnt <= '0;
          bitCnt  <= '0;
          state   <= ST_DATA;
        end
        ST_DATA: if (bitEnd) begin
          tickCnt <= '0;
          if (bitCnt == bitLast) state <= parityEn ? ST_PARITY : ST_STOP;
          else                   bitCnt <= bitCnt + 1'b1;
        end
        ST_PARITY: if (bitEnd) begin
          tickCnt <= '0;
          state   <= ST_STOP;
        end
        ST_STOP: if (stopEnd) begin
          tickCnt <= '0;
          state   <= startOk ? ST_START : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_tx_data.sv
module async_tx_data
  import async_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  txState_t   state,
  input  logic [7:0] loadData,
  input  logic [1:0] wordSel,
  input  logic       parityEven,
  input  logic       parityStick,
  input  logic       breakOn,
  output logic       txOut
);
  logic [7:0] shiftReg;
  logic       parBit;
  logic [7:0] masked;
  logic       xorAll;
  logic       parNext;

  assign masked  = loadData & (8'hFF >> (3'd3 - {1'b0, wordSel}));
  assign xorAll  = ^masked;
  assign parNext = parityStick ? !parityEven : (parityEven ? xorAll : !xorAll);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= masked;
      parBit   <= parNext;
    end else if (strobe.shift) begin
      shiftReg <= {1'b0, shiftReg[7:1]};
    end
  end

  always_comb begin
    unique case (state)
      ST_START:  txOut = 1'b0;
      ST_DATA:   txOut = shiftReg[0];
      ST_PARITY: txOut = parBit;
      default:   txOut = 1'b1;
    endcase
    if (breakOn) txOut = 1'b0;
  end
endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divValue,
  input  logic [1:0]       wordSel,
  input  logic             stopSel,
  input  logic             parityEn,
  input  logic             parityEven,
  input  logic             parityStick,
  input  logic             breakOn,
  input  logic             autoCtsEn,
  input  logic             ctsIn,
  output logic             txOut,
  output logic             holdEmpty,
  output logic             txEmpty
);
  logic      tick;
  logic      fifoEmpty;
  logic [7:0] headData;
  logic      busy;
  dpStrobe_t strobe;
  txState_t  state;

  async_tx_baud #(.DIV_W(DIV_W)) uBaud (
    .clk(clk), .rstN(rstN), .divWrEn(divWrEn), .divValue(divValue), .tick(tick)
  );

  async_tx_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) uFifo (
    .clk(clk), .rstN(rstN), .push(wrEn), .pushData(wrData),
    .pop(strobe.load), .popData(headData), .empty(fifoEmpty)
  );

  async_tx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .fifoEmpty(fifoEmpty),
    .ctsOk(!autoCtsEn || ctsIn), .wordSel(wordSel), .stopSel(stopSel),
    .parityEn(parityEn), .strobe(strobe), .state(state), .busy(busy)
  );

  async_tx_data uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .state(state), .loadData(headData),
    .wordSel(wordSel), .parityEven(parityEven), .parityStick(parityStick),
    .breakOn(breakOn), .txOut(txOut)
  );

  assign holdEmpty = fifoEmpty;
  assign txEmpty   = fifoEmpty && !busy;
endmodule

// File: rtl/async_tx_check.sv
module async_tx_check (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic breakOn,
  input logic autoCtsEn,
  input logic ctsIn,
  input logic txOut,
  input logic holdEmpty,
  input logic txEmpty,
  input logic shiftBusy
);
  // R1: line rests high when nothing is sent
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftBusy && !breakOn) |-> txOut);

  // R2: first cycle of a frame drives the start level
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(shiftBusy) && !breakOn) |-> !txOut);

  // R7: break overrides everything
  a_r7_break_low: assert property (@(posedge clk) disable iff (!rstN)
    breakOn |-> !txOut);

  // R8: closed gate keeps an idle transmitter idle
  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rstN)
    (autoCtsEn && !ctsIn && !shiftBusy) |=> !shiftBusy);

  // R9: transmitter-empty implies queue-empty
  a_r9_empty_order: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  // R9: a write clears transmitter-empty
  a_r9_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !txEmpty);
endmodule

bind async_tx async_tx_check uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .breakOn(breakOn),
  .autoCtsEn(autoCtsEn), .ctsIn(ctsIn), .txOut(txOut),
  .holdEmpty(holdEmpty), .txEmpty(txEmpty), .shiftBusy(busy)
);

// File: tb/async_tx_test.sv
module async_tx_test;
  typedef struct {
    logic [7:0] data;
    logic [1:0] ws;
    logic       stp;
    logic       pe;
    logic       ev;
    logic       st;
    bit         chained;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic divWrEn = 1'b0;
  logic [15:0] divValue = '0;
  logic [1:0] wordSel = 2'd3;
  logic stopSel = 1'b0, parityEn = 1'b0, parityEven = 1'b0, parityStick = 1'b0;
  logic breakOn = 1'b0, autoCtsEn = 1'b0, ctsIn = 1'b0;
  logic txOut, holdEmpty, txEmpty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int divEff = 1;
  int bitClk = 16;
  bit monOn = 1'b1;
  expItem_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_tx uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .divWrEn(divWrEn), .divValue(divValue), .wordSel(wordSel), .stopSel(stopSel),
    .parityEn(parityEn), .parityEven(parityEven), .parityStick(parityStick),
    .breakOn(breakOn), .autoCtsEn(autoCtsEn), .ctsIn(ctsIn),
    .txOut(txOut), .holdEmpty(holdEmpty), .txEmpty(txEmpty)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int stopTicks(input logic [1:0] ws, input logic stp);
    return !stp ? 16 : ((ws == 2'd0) ? 24 : 32);
  endfunction

  task automatic setDiv(input logic [15:0] v);
    @(negedge clk);
    divWrEn = 1'b1; divValue = v;
    @(negedge clk);
    divWrEn = 1'b0;
    divEff = (v == 16'd0) ? 1 : int'(v);
    bitClk = 16 * divEff;
  endtask

  task automatic setCfg(input logic [1:0] ws, input logic stp, input int mode);
    @(negedge clk);
    wordSel = ws; stopSel = stp;
    parityEn = (mode != 0);
    parityEven = (mode == 2) || (mode == 4);
    parityStick = (mode >= 3);
  endtask

  // driver: queue expected item then write; caller sits at a negedge
  task automatic sendByte(input logic [7:0] d, input bit chained);
    expItem_t it;
    it.data = d; it.ws = wordSel; it.stp = stopSel; it.pe = parityEn;
    it.ev = parityEven; it.st = parityStick; it.chained = chained;
    expQ.push_back(it);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (!txEmpty && n < 20000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(txEmpty == 1'b1, req, txEmpty, 1);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  // monitor: decode each frame and compare against the scoreboard
  initial begin
    int prevStart = 0;
    int prevLen = 0;
    bit prevValid = 1'b0;
    forever begin
      @(negedge clk);
      if (monOn && rstN && txOut == 1'b0) begin
        expItem_t it;
        int nBits;
        int startCyc;
        logic [7:0] got;
        logic [7:0] m;
        logic expPar;
        startCyc = cyc;
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected frame", 0, 1);
          it.data = 0; it.ws = 3; it.stp = 0; it.pe = 0; it.ev = 0; it.st = 0; it.chained = 0;
        end else begin
          it = expQ.pop_front();
        end
        if (it.chained && prevValid)
          check(startCyc - prevStart == prevLen, "R10 R5 R6 frame spacing", startCyc - prevStart, prevLen);
        nBits = 5 + int'(it.ws);
        repeat (bitClk / 2) @(negedge clk);
        check(txOut == 1'b0, "R2 start bit", txOut, 0);
        got = '0;
        for (int i = 0; i < nBits; i++) begin
          repeat (bitClk) @(negedge clk);
          got[i] = txOut;
        end
        m = it.data & (8'hFF >> (3 - int'(it.ws)));
        check(got == m, "R3 R2 data bits", got, m);
        if (it.pe) begin
          repeat (bitClk) @(negedge clk);
          expPar = it.st ? !it.ev : (it.ev ? ^m : !(^m));
          check(txOut == expPar, "R4 parity bit", txOut, expPar);
        end
        repeat (bitClk) @(negedge clk);
        check(txOut == 1'b1, "R5 first stop bit", txOut, 1);
        if (it.stp && it.ws != 2'd0) begin
          repeat (bitClk) @(negedge clk);
          check(txOut == 1'b1, "R5 second stop bit", txOut, 1);
        end
        prevStart = startCyc;
        prevLen = (1 + nBits + (it.pe ? 1 : 0)) * bitClk + stopTicks(it.ws, it.stp) * divEff;
        prevValid = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txOut == 1'b1, "R1 reset txOut", txOut, 1);
    check(holdEmpty == 1'b1, "R1 reset holdEmpty", holdEmpty, 1);
    check(txEmpty == 1'b1, "R1 reset txEmpty", txEmpty, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txOut == 1'b1, "R1 idle line", txOut, 1);

    // R9: status timing at D=1
    wrEn = 1'b1; wrData = 8'hA5;
    begin
      expItem_t it;
      it.data = 8'hA5; it.ws = 3; it.stp = 0; it.pe = 0; it.ev = 0; it.st = 0; it.chained = 0;
      expQ.push_back(it);
    end
    @(negedge clk);
    wrEn = 1'b0;
    check(holdEmpty == 1'b0, "R9 holdEmpty after write", holdEmpty, 0);
    check(txEmpty == 1'b0, "R9 txEmpty after write", txEmpty, 0);
    @(negedge clk);
    check(holdEmpty == 1'b1, "R9 holdEmpty after take", holdEmpty, 1);
    check(txEmpty == 1'b0, "R9 txEmpty while sending", txEmpty, 0);
    waitIdle("R9 drain");

    // R3 R4 R10: every word length and parity mode, two chained frames each
    for (int ws = 0; ws < 4; ws++) begin
      for (int md = 0; md < 5; md++) begin
        logic [7:0] d;
        d = 8'(8'h35 + ws * 37 + md * 11);
        setCfg(2'(ws), 1'b0, md);
        sendByte(d, 1'b0);
        sendByte(~d, 1'b1);
        waitIdle("R3 R4 burst");
      end
    end

    // R5: long stop times, spacing checked by chained frames
    setCfg(2'd0, 1'b1, 0);
    sendByte(8'h13, 1'b0); sendByte(8'h0E, 1'b1); sendByte(8'h1F, 1'b1);
    waitIdle("R5 1.5 stop");
    setCfg(2'd3, 1'b1, 1);
    sendByte(8'hC3, 1'b0); sendByte(8'h3C, 1'b1);
    waitIdle("R5 2 stop");

    // R6: divisor 3, then divisor 0 as 1
    setCfg(2'd3, 1'b0, 2);
    setDiv(16'd3);
    sendByte(8'h96, 1'b0); sendByte(8'h01, 1'b1);
    waitIdle("R6 div 3");
    setDiv(16'd0);
    sendByte(8'h7E, 1'b0); sendByte(8'h80, 1'b1);
    waitIdle("R6 div 0");

    // R7: break holds the line low, even during a frame
    monOn = 1'b0;
    breakOn = 1'b1;
    @(negedge clk);
    check(txOut == 1'b0, "R7 break idle", txOut, 0);
    wrEn = 1'b1; wrData = 8'hFF;
    @(negedge clk);
    wrEn = 1'b0;
    begin
      int highSeen = 0;
      int n = 0;
      while (!txEmpty && n < 5000) begin
        if (txOut) highSeen++;
        @(negedge clk);
        n++;
      end
      check(highSeen == 0, "R7 break during frame", highSeen, 0);
    end
    breakOn = 1'b0;
    @(negedge clk);
    check(txOut == 1'b1, "R7 break released", txOut, 1);
    monOn = 1'b1;

    // R8: gated start
    autoCtsEn = 1'b1; ctsIn = 1'b0;
    @(negedge clk);
    sendByte(8'h5A, 1'b0);
    begin
      int lowSeen = 0;
      for (int i = 0; i < 300; i++) begin
        if (!txOut) lowSeen++;
        @(negedge clk);
      end
      check(lowSeen == 0, "R8 line held while gated", lowSeen, 0);
      check(holdEmpty == 1'b0, "R8 byte waits while gated", holdEmpty, 0);
      check(txEmpty == 1'b0, "R8 txEmpty while gated", txEmpty, 0);
    end
    ctsIn = 1'b1;
    waitIdle("R8 released");
    autoCtsEn = 1'b0;

    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule